// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between a simple host bus and the internal operation engine of a NOR-style flash. The host writes byte-wide command codes, and one or two writes together make a command. The decoder uses them to pick what later reads return: array contents, the status byte, identification bytes or query bytes. It also starts block erase, whole-array erase and word program operations, and it can suspend and resume them. The operation engine is modelled with counters. A small stub array is held in inferable block RAM, and the engine erases it one word per cycle.

An 8-bit status byte reports readiness, the two suspend states and sticky error flags. A ready/busy output follows engine activity. A configuration command can instead set this output to give a one-cycle low pulse when an erase completes, when a program completes, or both. A synchronous reset aborts any running operation and returns the decoder to its initial state.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the ready/busy output is high, any running operation is abandoned, reads return array data, and the status byte reads 80h.
- R2: A read strobe returns data one cycle later with rd_valid set. After writing FFh, reads return the array word. After 70h they return the status byte. After 90h, address 0 returns the manufacturer byte (5Ah by default), address 1 returns the device byte (C3h) and any other address returns 00h. After 98h, addresses 10h, 11h and 12h return 51h, 52h and 59h, and any other address returns 00h.
- R3: 40h or 10h followed by a write of address and data programs that word. The output is low for exactly PROG_CYCLES cycles, the data is then stored, and reads switch to status.
- R4: 20h followed by D0h at any address in a block sets every word of that block to FFh over BLOCK_WORDS busy cycles, and leaves the other blocks unchanged. The block is the top BLK_BITS of the address.
- R5: 30h followed by D0h sets every word of the array to FFh.
- R6: If the second write of 20h or 30h is not D0h, no operation starts and status bits 5 and 4 both set (status B0h). 50h clears bits 5 and 4.
- R7: A read issued while an operation is running returns the status byte, with bit 7 = 0, whatever read mode was selected.
- R8: B0h during an erase suspends it. The output goes high and status bit 6 sets (C0h). Array reads and a program to another block are then allowed. A program to the block being erased is refused and sets bit 4. D0h resumes the erase, which then completes.
- R9: B0h during a program suspends it. The output goes high and status bit 2 sets (84h). Reads are allowed. A new program setup is refused and sets bit 4. D0h resumes the program.
- R10: In level mode the output is low while a program or an unsuspended erase runs. It is high when idle, when the erase is suspended with no program active, and when a program is suspended.
- R11: B8h followed by a code selects the output mode: 00h level, 01h low pulse on erase completion, 02h low pulse on program completion, 03h both. In a pulse mode the output is otherwise high. A code above 03h sets status bits 5 and 4.
- R12: While an operation is running, every write other than 70h and B0h is ignored.
- R13: An erase setup (20h or 30h) while an erase is suspended is refused and sets status bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Host write strobe, one cycle per write |
| bus_re | input | 1 | Host read strobe |
| bus_addr | input | AW | Host word address |
| bus_wdata | input | 8 | Command or program data |
| rd_data | output | 8 | Read return data |
| rd_valid | output | 1 | rd_data valid, one cycle after bus_re |
| rdy_busy | output | 1 | Ready/busy or completion-pulse output |

## Verification
The bench nests operations: it programs one block while an erase in another block is suspended, and it checks that a program aimed at the suspended block is refused. A decoder that got this wrong would corrupt data that the erase has not yet reached. The bench reads with the array mode selected while an operation runs, so a design that ignored the running state would return stale array bytes instead of status. It writes commands while the engine is busy and afterwards checks the read mode and the memory. It compares the counted busy lengths and completion pulses with the parameters. It also resets in the middle of a chip erase and checks that a word outside the erased region survives and that status is 80h.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;
  localparam int CMD_W = 8;

  // command codes
  localparam logic [CMD_W-1:0] CMD_ARRAY      = 8'hFF;
  localparam logic [CMD_W-1:0] CMD_STATUS     = 8'h70;
  localparam logic [CMD_W-1:0] CMD_IDENT      = 8'h90;
  localparam logic [CMD_W-1:0] CMD_QUERY      = 8'h98;
  localparam logic [CMD_W-1:0] CMD_CLEAR      = 8'h50;
  localparam logic [CMD_W-1:0] CMD_PROG_A     = 8'h40;
  localparam logic [CMD_W-1:0] CMD_PROG_B     = 8'h10;
  localparam logic [CMD_W-1:0] CMD_BLK_ERASE  = 8'h20;
  localparam logic [CMD_W-1:0] CMD_CHIP_ERASE = 8'h30;
  localparam logic [CMD_W-1:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [CMD_W-1:0] CMD_SUSPEND    = 8'hB0;
  localparam logic [CMD_W-1:0] CMD_RB_CFG     = 8'hB8;

  // status byte bit positions
  localparam int SB_READY = 7;
  localparam int SB_ESUSP = 6;
  localparam int SB_EERR  = 5;
  localparam int SB_PERR  = 4;
  localparam int SB_PSUSP = 2;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_IDENT  = 2'd2,
    RM_QUERY  = 2'd3
  } rd_mode_e;

  typedef enum logic [2:0] {
    DS_IDLE   = 3'd0,
    DS_PROG   = 3'd1,
    DS_BERASE = 3'd2,
    DS_CERASE = 3'd3,
    DS_CFG    = 3'd4
  } dec_state_e;

  typedef enum logic [1:0] {
    RB_LEVEL       = 2'd0,
    RB_PULSE_ERASE = 2'd1,
    RB_PULSE_PROG  = 2'd2,
    RB_PULSE_BOTH  = 2'd3
  } rb_cfg_e;
endpackage

// File: rtl/fcd_array.sv
`timescale 1ns/1ps
module fcd_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // simple dual-port, read-first: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    q <= mem[ra];
  end
endmodule

// File: rtl/fcd_engine.sv
`timescale 1ns/1ps
module fcd_engine #(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int BLK_BITS    = 2,
  parameter int PROG_CYCLES = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                launch_prog,
  input  logic                launch_berase,
  input  logic                launch_cerase,
  input  logic                req_susp,
  input  logic                req_resume,
  input  logic [AW-1:0]       op_addr,
  input  logic [DW-1:0]       op_data,
  output logic                wr_en,
  output logic [AW-1:0]       wr_addr,
  output logic [DW-1:0]       wr_data,
  output logic                running,
  output logic                erase_active,
  output logic                erase_susp,
  output logic                erase_whole,
  output logic [BLK_BITS-1:0] erase_blk,
  output logic                prog_active,
  output logic                prog_susp,
  output logic                erase_done,
  output logic                prog_done
);
  localparam int OFF_W = AW - BLK_BITS;
  localparam int PCW   = $clog2(PROG_CYCLES + 1);

  logic [AW-1:0]  erase_ptr, erase_last;
  logic [PCW-1:0] prog_cnt;
  logic [AW-1:0]  prog_addr;
  logic [DW-1:0]  prog_data;
  logic           prog_run, erase_run;

  assign prog_run  = prog_active && !prog_susp;
  assign erase_run = erase_active && !erase_susp && !prog_active;
  assign running   = prog_run || erase_run;

  assign wr_en   = erase_run || (prog_run && prog_cnt == '0);
  assign wr_addr = prog_run ? prog_addr : erase_ptr;
  assign wr_data = prog_run ? prog_data : {DW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      erase_active <= 1'b0;
      erase_susp   <= 1'b0;
      erase_whole  <= 1'b0;
      erase_blk    <= '0;
      erase_ptr    <= '0;
      erase_last   <= '0;
      prog_active  <= 1'b0;
      prog_susp    <= 1'b0;
      prog_cnt     <= '0;
      prog_addr    <= '0;
      prog_data    <= '0;
      erase_done   <= 1'b0;
      prog_done    <= 1'b0;
    end else begin
      erase_done <= 1'b0;
      prog_done  <= 1'b0;
      // progress of the active operation; completion wins over suspend
      if (prog_run) begin
        if (prog_cnt == '0) begin
          prog_active <= 1'b0;
          prog_done   <= 1'b1;
        end else begin
          prog_cnt <= prog_cnt - 1'b1;
          if (req_susp) prog_susp <= 1'b1;
        end
      end else if (erase_run) begin
        erase_ptr <= erase_ptr + 1'b1;
        if (erase_ptr == erase_last) begin
          erase_active <= 1'b0;
          erase_done   <= 1'b1;
        end else if (req_susp) begin
          erase_susp <= 1'b1;
        end
      end
      // resume: innermost suspended operation first
      if (req_resume) begin
        if (prog_susp) prog_susp <= 1'b0;
        else if (erase_susp && !prog_active) erase_susp <= 1'b0;
      end
      if (launch_prog) begin
        prog_active <= 1'b1;
        prog_susp   <= 1'b0;
        prog_cnt    <= PCW'(PROG_CYCLES - 1);
        prog_addr   <= op_addr;
        prog_data   <= op_data;
      end
      if (launch_berase) begin
        erase_active <= 1'b1;
        erase_susp   <= 1'b0;
        erase_whole  <= 1'b0;
        erase_blk    <= op_addr[AW-1 -: BLK_BITS];
        erase_ptr    <= {op_addr[AW-1 -: BLK_BITS], {OFF_W{1'b0}}};
        erase_last   <= {op_addr[AW-1 -: BLK_BITS], {OFF_W{1'b1}}};
      end
      if (launch_cerase) begin
        erase_active <= 1'b1;
        erase_susp   <= 1'b0;
        erase_whole  <= 1'b1;
        erase_blk    <= '0;
        erase_ptr    <= '0;
        erase_last   <= {AW{1'b1}};
      end
    end
  end
endmodule

// File: rtl/fcd_decoder.sv
`timescale 1ns/1ps
module fcd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int BLK_BITS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_we,
  input  logic [CMD_W-1:0]    bus_wdata,
  input  logic [BLK_BITS-1:0] wr_blk,
  input  logic                running,
  input  logic                erase_active,
  input  logic                erase_susp,
  input  logic                erase_whole,
  input  logic [BLK_BITS-1:0] erase_blk,
  input  logic                prog_active,
  output rd_mode_e            mode,
  output rb_cfg_e             rb_cfg,
  output logic                eerr,
  output logic                perr,
  output logic                launch_prog,
  output logic                launch_berase,
  output logic                launch_cerase,
  output logic                req_susp,
  output logic                req_resume
);
  dec_state_e state, state_n;
  rd_mode_e   mode_n;
  rb_cfg_e    cfg_n;
  logic       eerr_n, perr_n, clr_err, blk_conflict;

  assign blk_conflict = erase_susp && (erase_whole || wr_blk == erase_blk);

  always_comb begin
    state_n       = state;
    mode_n        = mode;
    cfg_n         = rb_cfg;
    eerr_n        = 1'b0;
    perr_n        = 1'b0;
    clr_err       = 1'b0;
    launch_prog   = 1'b0;
    launch_berase = 1'b0;
    launch_cerase = 1'b0;
    req_susp      = 1'b0;
    req_resume    = 1'b0;
    if (bus_we) begin
      unique case (state)
        DS_IDLE: begin
          if (running) begin
            if (bus_wdata == CMD_STATUS)  mode_n   = RM_STATUS;
            if (bus_wdata == CMD_SUSPEND) req_susp = 1'b1;
          end else begin
            case (bus_wdata)
              CMD_ARRAY:   mode_n = RM_ARRAY;
              CMD_STATUS:  mode_n = RM_STATUS;
              CMD_IDENT:   mode_n = RM_IDENT;
              CMD_QUERY:   mode_n = RM_QUERY;
              CMD_CLEAR:   clr_err = 1'b1;
              CMD_SUSPEND: req_susp = 1'b1;
              CMD_CONFIRM: req_resume = 1'b1;
              CMD_RB_CFG:  state_n = DS_CFG;
              CMD_PROG_A, CMD_PROG_B: begin
                if (prog_active) perr_n = 1'b1;
                else             state_n = DS_PROG;
              end
              CMD_BLK_ERASE: begin
                if (erase_active) eerr_n = 1'b1;
                else              state_n = DS_BERASE;
              end
              CMD_CHIP_ERASE: begin
                if (erase_active) eerr_n = 1'b1;
                else              state_n = DS_CERASE;
              end
              default: ;
            endcase
          end
        end
        DS_PROG: begin
          state_n = DS_IDLE;
          mode_n  = RM_STATUS;
          if (blk_conflict) perr_n = 1'b1;
          else              launch_prog = 1'b1;
        end
        DS_BERASE, DS_CERASE: begin
          state_n = DS_IDLE;
          mode_n  = RM_STATUS;
          if (bus_wdata != CMD_CONFIRM) begin
            eerr_n = 1'b1;
            perr_n = 1'b1;
          end else if (state == DS_BERASE) begin
            launch_berase = 1'b1;
          end else begin
            launch_cerase = 1'b1;
          end
        end
        DS_CFG: begin
          state_n = DS_IDLE;
          if (bus_wdata[CMD_W-1:2] == '0) begin
            cfg_n = rb_cfg_e'(bus_wdata[1:0]);
          end else begin
            eerr_n = 1'b1;
            perr_n = 1'b1;
          end
        end
        default: state_n = DS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= DS_IDLE;
      mode   <= RM_ARRAY;
      rb_cfg <= RB_LEVEL;
      eerr   <= 1'b0;
      perr   <= 1'b0;
    end else begin
      state  <= state_n;
      mode   <= mode_n;
      rb_cfg <= cfg_n;
      eerr   <= (eerr && !clr_err) || eerr_n;
      perr   <= (perr && !clr_err) || perr_n;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
`timescale 1ns/1ps
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int AW          = 8,
  parameter int BLK_BITS    = 2,
  parameter int PROG_CYCLES = 6,
  parameter logic [7:0] MFG_BYTE = 8'h5A,
  parameter logic [7:0] DEV_BYTE = 8'hC3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    rd_data,
  output logic          rd_valid,
  output logic          rdy_busy
);
  localparam int DW = CMD_W;
  localparam logic [AW-1:0] QRY_BASE = AW'(16);

  rd_mode_e            mode;
  rb_cfg_e             rb_cfg;
  logic                eerr, perr;
  logic                launch_prog, launch_berase, launch_cerase;
  logic                req_susp, req_resume;
  logic                wr_en;
  logic [AW-1:0]       wr_addr;
  logic [DW-1:0]       wr_data;
  logic                running, erase_active, erase_susp, erase_whole;
  logic [BLK_BITS-1:0] erase_blk;
  logic                prog_active, prog_susp;
  logic                erase_done, prog_done;
  logic [DW-1:0]       mem_q, info_byte, info_q, status_byte;
  logic                sel_array_q, rb_level;

  fcd_decoder #(.BLK_BITS(BLK_BITS)) i_dec (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .wr_blk(bus_addr[AW-1 -: BLK_BITS]), .running(running),
    .erase_active(erase_active), .erase_susp(erase_susp),
    .erase_whole(erase_whole), .erase_blk(erase_blk),
    .prog_active(prog_active), .mode(mode), .rb_cfg(rb_cfg),
    .eerr(eerr), .perr(perr), .launch_prog(launch_prog),
    .launch_berase(launch_berase), .launch_cerase(launch_cerase),
    .req_susp(req_susp), .req_resume(req_resume)
  );

  fcd_engine #(.AW(AW), .DW(DW), .BLK_BITS(BLK_BITS), .PROG_CYCLES(PROG_CYCLES)) i_eng (
    .clk(clk), .rst(rst), .launch_prog(launch_prog),
    .launch_berase(launch_berase), .launch_cerase(launch_cerase),
    .req_susp(req_susp), .req_resume(req_resume),
    .op_addr(bus_addr), .op_data(bus_wdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .running(running), .erase_active(erase_active), .erase_susp(erase_susp),
    .erase_whole(erase_whole), .erase_blk(erase_blk),
    .prog_active(prog_active), .prog_susp(prog_susp),
    .erase_done(erase_done), .prog_done(prog_done)
  );

  fcd_array #(.AW(AW), .DW(DW)) i_arr (
    .clk(clk), .we(wr_en), .wa(wr_addr), .wd(wr_data),
    .ra(bus_addr), .q(mem_q)
  );

  always_comb begin
    status_byte           = '0;
    status_byte[SB_READY] = !running;
    status_byte[SB_ESUSP] = erase_susp;
    status_byte[SB_EERR]  = eerr;
    status_byte[SB_PERR]  = perr;
    status_byte[SB_PSUSP] = prog_susp;
  end

  // non-array read sources; a running engine forces status
  always_comb begin
    info_byte = '0;
    if (running || mode == RM_STATUS) begin
      info_byte = status_byte;
    end else if (mode == RM_IDENT) begin
      if (bus_addr == AW'(0))      info_byte = MFG_BYTE;
      else if (bus_addr == AW'(1)) info_byte = DEV_BYTE;
    end else if (mode == RM_QUERY) begin
      if (bus_addr == QRY_BASE)             info_byte = 8'h51;
      else if (bus_addr == QRY_BASE + 1'b1) info_byte = 8'h52;
      else if (bus_addr == QRY_BASE + 2'd2) info_byte = 8'h59;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid    <= 1'b0;
      sel_array_q <= 1'b0;
      info_q      <= '0;
    end else begin
      rd_valid <= bus_re;
      if (bus_re) begin
        sel_array_q <= !running && mode == RM_ARRAY;
        info_q      <= info_byte;
      end
    end
  end

  assign rd_data  = sel_array_q ? mem_q : info_q;
  assign rb_level = (rb_cfg == RB_LEVEL);
  assign rdy_busy = rb_level ? !running
                             : !((rb_cfg[0] && erase_done) || (rb_cfg[1] && prog_done));
endmodule

// File: rtl/fcd_checker.sv
`timescale 1ns/1ps
module fcd_checker (
  input logic       clk,
  input logic       rst,
  input logic       bus_re,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       rdy_busy,
  input logic       running,
  input logic       erase_active,
  input logic       erase_susp,
  input logic       prog_active,
  input logic       prog_susp,
  input logic       rb_level,
  input logic [7:0] status_byte
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rdy_busy && status_byte == 8'h80)); // R1
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> rd_valid); // R2
  AST_BUSY_READS_STATUS: assert property (@(posedge clk) disable iff (rst)
    (bus_re && running) |=> (rd_data[7] == 1'b0)); // R7
  AST_ESUSP_HAS_ERASE: assert property (@(posedge clk) disable iff (rst)
    erase_susp |-> erase_active); // R8
  AST_NO_PROG_UNDER_ERASE: assert property (@(posedge clk) disable iff (rst)
    !(erase_active && !erase_susp && prog_active)); // R8
  AST_PSUSP_HAS_PROG: assert property (@(posedge clk) disable iff (rst)
    prog_susp |-> prog_active); // R9
  AST_ESUSP_READY: assert property (@(posedge clk) disable iff (rst)
    (rb_level && erase_susp && !prog_active) |-> rdy_busy); // R10
  AST_PSUSP_READY: assert property (@(posedge clk) disable iff (rst)
    (rb_level && prog_susp) |-> rdy_busy); // R10
endmodule

bind flash_cmd_decoder fcd_checker i_fcd_checker (
  .clk(clk), .rst(rst), .bus_re(bus_re), .rd_valid(rd_valid),
  .rd_data(rd_data), .rdy_busy(rdy_busy), .running(running),
  .erase_active(erase_active), .erase_susp(erase_susp),
  .prog_active(prog_active), .prog_susp(prog_susp),
  .rb_level(rb_level), .status_byte(status_byte)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
  localparam int AW = 8;
  localparam int PROG_CYCLES = 6;
  localparam int BLOCK_WORDS = 64;
  localparam int NV = 47;
  // vector: {op[1:0], addr[7:0], data[7:0], expect[7:0], req[3:0]}
  // op 0 = write, 1 = read and compare, 2 = wait for ready
  localparam logic [29:0] VEC [NV] = '{
    {2'd0, 8'h00, 8'h30, 8'h00, 4'd5},  // R5 chip erase setup
    {2'd0, 8'h00, 8'hD0, 8'h00, 4'd5},  // R5 confirm
    {2'd2, 8'h00, 8'h00, 8'h00, 4'd5},
    {2'd0, 8'h00, 8'hFF, 8'h00, 4'd2},  // R2 array mode
    {2'd1, 8'h05, 8'h00, 8'hFF, 4'd5},  // R5 erased word
    {2'd0, 8'h00, 8'h40, 8'h00, 4'd3},  // R3 program setup 40h
    {2'd0, 8'h05, 8'hA5, 8'h00, 4'd3},
    {2'd2, 8'h00, 8'h00, 8'h00, 4'd3},
    {2'd1, 8'h00, 8'h00, 8'h80, 4'd3},  // R3 reads switch to status
    {2'd0, 8'h00, 8'hFF, 8'h00, 4'd2},
    {2'd1, 8'h05, 8'h00, 8'hA5, 4'd3},  // R3 stored word
    {2'd0, 8'h00, 8'h10, 8'h00, 4'd3},  // R3 alternate setup 10h
    {2'd0, 8'h45, 8'h3C, 8'h00, 4'd3},
    {2'd2, 8'h00, 8'h00, 8'h00, 4'd3},
    {2'd0, 8'h00, 8'hFF, 8'h00, 4'd2},
    {2'd1, 8'h45, 8'h00, 8'h3C, 4'd3},
    {2'd0, 8'h00, 8'h90, 8'h00, 4'd2},  // R2 identifier mode
    {2'd1, 8'h00, 8'h00, 8'h5A, 4'd2},
    {2'd1, 8'h01, 8'h00, 8'hC3, 4'd2},
    {2'd1, 8'h02, 8'h00, 8'h00, 4'd2},
    {2'd0, 8'h00, 8'h98, 8'h00, 4'd2},  // R2 query mode
    {2'd1, 8'h10, 8'h00, 8'h51, 4'd2},
    {2'd1, 8'h11, 8'h00, 8'h52, 4'd2},
    {2'd1, 8'h12, 8'h00, 8'h59, 4'd2},
    {2'd1, 8'h13, 8'h00, 8'h00, 4'd2},
    {2'd0, 8'h00, 8'h70, 8'h00, 4'd2},  // R2 status mode
    {2'd1, 8'h33, 8'h00, 8'h80, 4'd2},
    {2'd0, 8'h00, 8'h20, 8'h00, 4'd4},  // R4 erase block 1
    {2'd0, 8'h40, 8'hD0, 8'h00, 4'd4},
    {2'd2, 8'h00, 8'h00, 8'h00, 4'd4},
    {2'd1, 8'h00, 8'h00, 8'h80, 4'd4},
    {2'd0, 8'h00, 8'hFF, 8'h00, 4'd4},
    {2'd1, 8'h45, 8'h00, 8'hFF, 4'd4},  // R4 erased in block 1
    {2'd1, 8'h05, 8'h00, 8'hA5, 4'd4},  // R4 block 0 untouched
    {2'd0, 8'h00, 8'h20, 8'h00, 4'd6},  // R6 bad confirm
    {2'd0, 8'h05, 8'h77, 8'h00, 4'd6},
    {2'd1, 8'h00, 8'h00, 8'hB0, 4'd6},
    {2'd0, 8'h00, 8'h50, 8'h00, 4'd6},  // R6 clear status
    {2'd1, 8'h00, 8'h00, 8'h80, 4'd6},
    {2'd0, 8'h00, 8'hFF, 8'h00, 4'd6},
    {2'd1, 8'h05, 8'h00, 8'hA5, 4'd6},  // R6 nothing erased
    {2'd0, 8'h00, 8'hB8, 8'h00, 4'd11}, // R11 invalid config code
    {2'd0, 8'h00, 8'h09, 8'h00, 4'd11},
    {2'd0, 8'h00, 8'h70, 8'h00, 4'd11},
    {2'd1, 8'h00, 8'h00, 8'hB0, 4'd11},
    {2'd0, 8'h00, 8'h50, 8'h00, 4'd11},
    {2'd1, 8'h00, 8'h00, 8'h80, 4'd11}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    rd_data;
  logic          rd_valid;
  logic          rdy_busy;
  int            checks = 0;
  int            failures = 0;
  logic [7:0]    rv;
  int            cnt;

  always #2 clk = ~clk;

  flash_cmd_decoder #(.AW(AW), .BLK_BITS(2), .PROG_CYCLES(PROG_CYCLES)) i_flash_cmd_decoder (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .rdy_busy(rdy_busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_ready(input int lim, output int n);
    n = 0;
    while (!rdy_busy && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic count_low(input int span, output int n);
    n = 0;
    for (int k = 0; k < span; k++) begin
      if (!rdy_busy) n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", rdy_busy, 1);
    chk("R1 no read data after reset", rd_valid, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      v = VEC[i];
      case (v[29:28])
        2'd0: wr(v[27:20], v[19:12]);
        2'd1: begin
          rd(v[27:20], rv);
          chk($sformatf("R%0d vector %0d", v[3:0], i), rv, v[11:4]);
        end
        default: wait_ready(1000, cnt);
      endcase
    end

    // R3 busy length and R10 low while programming
    wr(8'h00, 8'h40); wr(8'h90, 8'h66);
    chk("R10 low during program", rdy_busy, 0);
    wait_ready(1000, cnt);
    chk("R3 program busy cycles", cnt, PROG_CYCLES);
    wr(8'h00, 8'hFF); rd(8'h90, rv);
    chk("R3 programmed 90h", rv, 8'h66);

    // R4 busy length, R12 writes ignored while busy
    wr(8'h00, 8'h20); wr(8'h80, 8'hD0);
    wr(8'h00, 8'hFF); wr(8'h00, 8'h40); wr(8'h0B, 8'h99);
    wait_ready(1000, cnt);
    chk("R4 erase busy cycles", cnt + 3, BLOCK_WORDS);
    rd(8'h00, rv);
    chk("R12 mode write ignored while busy", rv, 8'h80);
    wr(8'h00, 8'hFF); rd(8'h0B, rv);
    chk("R12 program ignored while busy", rv, 8'hFF);
    rd(8'h90, rv);
    chk("R4 block 2 erased", rv, 8'hFF);

    // R8 erase suspend with nested program, R13, R7
    wr(8'h00, 8'h40); wr(8'h85, 8'h21); wait_ready(1000, cnt);
    wr(8'h00, 8'h20); wr(8'h85, 8'hD0);
    @(negedge clk); @(negedge clk);
    wr(8'h00, 8'hB0);
    chk("R8 high when erase suspended", rdy_busy, 1);
    rd(8'h00, rv);
    chk("R8 status erase suspended", rv, 8'hC0);
    wr(8'h00, 8'hFF); rd(8'h85, rv);
    chk("R8 unerased word readable", rv, 8'h21);
    rd(8'h05, rv);
    chk("R8 other block readable", rv, 8'hA5);
    wr(8'h00, 8'h40); wr(8'h06, 8'h11);
    chk("R10 low for program in erase suspend", rdy_busy, 0);
    wait_ready(1000, cnt);
    rd(8'h00, rv);
    chk("R8 status after nested program", rv, 8'hC0);
    wr(8'h00, 8'h40); wr(8'h88, 8'h22);
    rd(8'h00, rv);
    chk("R8 program into suspended block refused", rv, 8'hD0);
    wr(8'h00, 8'h50);
    wr(8'h00, 8'h20);
    rd(8'h00, rv);
    chk("R13 erase setup during suspend", rv, 8'hE0);
    wr(8'h00, 8'h50);
    wr(8'h00, 8'hFF); wr(8'h00, 8'hD0);
    rd(8'h05, rv);
    chk("R7 array mode read while running", rv, 8'h00);
    wait_ready(1000, cnt);
    wr(8'h00, 8'hFF); rd(8'h85, rv);
    chk("R8 erase completes after resume", rv, 8'hFF);
    rd(8'h88, rv);
    chk("R8 refused program left no data", rv, 8'hFF);
    rd(8'h06, rv);
    chk("R8 nested program stored", rv, 8'h11);

    // R9 program suspend
    wr(8'h00, 8'h40); wr(8'h07, 8'h33); wr(8'h00, 8'hB0);
    chk("R9 high when program suspended", rdy_busy, 1);
    wr(8'h00, 8'h70); rd(8'h00, rv);
    chk("R9 status program suspended", rv, 8'h84);
    wr(8'h00, 8'hFF); rd(8'h07, rv);
    chk("R9 target not yet written", rv, 8'hFF);
    wr(8'h00, 8'h40); wr(8'h00, 8'h70); rd(8'h00, rv);
    chk("R9 new program refused", rv, 8'h94);
    wr(8'h00, 8'h50); wr(8'h00, 8'hD0);
    chk("R9 low after resume", rdy_busy, 0);
    wait_ready(1000, cnt);
    wr(8'h00, 8'hFF); rd(8'h07, rv);
    chk("R9 resumed program stored", rv, 8'h33);

    // R11 pulse modes
    wr(8'h00, 8'hB8); wr(8'h00, 8'h01);
    wr(8'h00, 8'h20); wr(8'hC0, 8'hD0);
    chk("R11 high during erase in pulse mode", rdy_busy, 1);
    count_low(100, cnt);
    chk("R11 one erase pulse", cnt, 1);
    wr(8'h00, 8'h40); wr(8'hC1, 8'h44);
    count_low(20, cnt);
    chk("R11 no pulse for program in erase mode", cnt, 0);
    wr(8'h00, 8'hB8); wr(8'h00, 8'h02);
    wr(8'h00, 8'h40); wr(8'hC2, 8'h55);
    count_low(20, cnt);
    chk("R11 one program pulse", cnt, 1);
    wr(8'h00, 8'hB8); wr(8'h00, 8'h00);
    wr(8'h00, 8'h40); wr(8'hC3, 8'h56);
    chk("R10 level mode restored", rdy_busy, 0);
    wait_ready(1000, cnt);

    // R1 reset during chip erase
    wr(8'h00, 8'h40); wr(8'hF0, 8'h5C); wait_ready(1000, cnt);
    wr(8'h00, 8'h30); wr(8'h00, 8'hD0);
    @(negedge clk); @(negedge clk);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R1 ready after abort", rdy_busy, 1);
    rd(8'hF0, rv);
    chk("R1 array mode and abort", rv, 8'h5C);
    wr(8'h00, 8'h70); rd(8'h00, rv);
    chk("R1 status 80h", rv, 8'h80);

    finish_run();
  end
endmodule